// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Address-Flag Framing

This block is a transmitter and receiver pair for start/stop framed serial lines. A character is eight data bits sent least significant bit first behind one low start bit, optionally followed by one extra bit and then one or two high stop bits. The extra bit is either a parity bit or, in address-flag framing, a flag that marks the character as an address (ID) or as plain data. A shared baud tick generator paces both directions. It takes the system clock through a prescaler with four settings and then divides it by a programmable bit-rate value to give a sixteen-times oversample tick.

The host hands bytes to the transmitter over a valid/ready handshake. It takes received bytes from a one-cycle strobe that carries the data, the flag bit and two error indications. All configuration is presented as static input levels that are held stable while characters are in flight. In address-flag framing a wait-for-ID input lets a listening station skip data characters until one addressed to the group arrives. When two stop bits are configured, the receiver still checks only the first, so a sender that starts its next character early in the second stop slot is received without error.

Top module: `async_mp_serial`

## Requirements
- R1: While idle the transmit line is high. An accepted byte is sent as a low start bit, then the eight data bits least significant first, then the extra bit when one is active, then the stop bits at logic 1. tx_ready is low from acceptance until the last stop bit ends.
- R2: cfg_two_stop = 0 appends one stop bit and cfg_two_stop = 1 appends two. A frame therefore lasts 16 oversample ticks per bit for 10, 11 or 12 bits.
- R3: The oversample tick period is (cfg_bit_rate + 1) × D system clocks, where D is 1, 4, 16 or 64 for cfg_clk_sel codes 0, 1, 2 and 3.
- R4: With cfg_parity_en = 1 and cfg_mp_mode = 0, a parity bit is sent after the data. cfg_parity_odd = 0 makes the number of ones across data and parity even, and cfg_parity_odd = 1 makes it odd.
- R5: With cfg_mp_mode = 1 the extra bit always exists and carries tx_flag (1 = ID, 0 = data). The parity settings are then ignored: no parity bit is generated and rx_parity_err never rises. The received extra bit appears on rx_flag; rx_flag is 0 outside this mode.
- R6: The receiver accepts a start bit only if the line is still low 8 ticks after the falling edge was seen. A low pulse shorter than that produces no character.
- R7: After it samples the first stop bit at its centre, the receiver raises rx_valid for exactly one cycle with rx_data and rx_flag.
- R8: rx_frame_err rises together with rx_valid when the first stop bit is sampled low.
- R9: rx_parity_err rises together with rx_valid when parity is enabled, address-flag mode is off, and the received parity bit does not match cfg_parity_odd. Both error strobes may rise on the same character.
- R10: Only the first stop bit is checked, whatever cfg_two_stop is. A low line in the second stop slot is taken as the start of the next character, and both characters are delivered without error.
- R11: With cfg_mp_mode = 1 and cfg_wait_id = 1, characters with flag 0 are dropped with no rx_valid and no error strobe. A character with flag 1 is delivered.
- R12: After reset txd = 1, tx_ready = 1, and rx_valid, rx_frame_err and rx_parity_err are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| cfg_parity_en | input | 1 | Parity bit enable (normal framing only) |
| cfg_parity_odd | input | 1 | 0: even parity, 1: odd parity |
| cfg_mp_mode | input | 1 | Address-flag framing enable |
| cfg_clk_sel | input | 2 | Prescaler select: divide by 1, 4, 16, 64 |
| cfg_bit_rate | input | 8 | Bit-rate divisor minus one |
| cfg_wait_id | input | 1 | Drop flag-0 characters in address-flag mode |
| tx_data | input | 8 | Byte to transmit |
| tx_flag | input | 1 | Address flag to transmit in address-flag mode |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter can accept a byte |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 8 | Received byte |
| rx_flag | output | 1 | Received address flag |
| rx_valid | output | 1 | One-cycle strobe for a received character |
| rx_frame_err | output | 1 | First stop bit was low |
| rx_parity_err | output | 1 | Parity mismatch |

## Verification
The two error checks of the receiver can complete in the same cycle, because both are decided when the first stop bit is sampled. The bench provokes this by driving the receive line with a character that has a wrong parity bit and a low stop bit. It then expects one rx_valid with rx_frame_err and rx_parity_err raised in that same cycle. A second coincidence is checked as well: the end of one character and the start of the next fall in the same bit slot, which the bench produces by pulling the second stop slot low. It then expects two clean characters.

// File: rtl/serial_mp_pkg.sv
package serial_mp_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2
   } rx_state_e;

   // Parity bit that makes data plus parity match the requested sense
   function automatic logic parity_bit(input logic [31:0] word, input int unsigned width,
                                       input logic odd);
      logic acc;
      acc = odd;
      for (int unsigned i = 0; i < width; i++) acc = acc ^ word[i];
      return acc;
   endfunction

endpackage

// File: rtl/mp_baud_gen.sv
module mp_baud_gen #(
   parameter int unsigned BRR_W   = 8,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned PRE_LOG = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] clk_sel,
   input  logic [BRR_W-1:0] bit_rate,
   output logic             tick
);
   localparam int unsigned N_TAPS = 1 << SEL_W;
   localparam int unsigned PRE_W  = PRE_LOG * (N_TAPS - 1);

   logic [PRE_W-1:0] pre_cnt;
   logic [N_TAPS-1:0] taps;
   logic             pre_en;
   logic [BRR_W-1:0] div_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_cnt <= '0;
      else        pre_cnt <= pre_cnt + 1'b1;
   end

   for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
      if (k == 0) begin : g_direct
         assign taps[k] = 1'b1;
      end else begin : g_div
         assign taps[k] = &pre_cnt[PRE_LOG*k-1:0];
      end
   end

   assign pre_en = taps[clk_sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
         tick    <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (pre_en) begin
            if (div_cnt >= bit_rate) begin
               div_cnt <= '0;
               tick    <= 1'b1;
            end else begin
               div_cnt <= div_cnt + 1'b1;
            end
         end
      end
   end

   // R3
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (clk_sel != '0 || bit_rate != '0)) |=> !tick);
   // R3
   tick_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tick) |-> $past(pre_en));

endmodule

// File: rtl/mp_tx.sv
module mp_tx #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              two_stop,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              mp_mode,
   input  logic [DATA_W-1:0] data,
   input  logic              flag,
   input  logic              valid,
   output logic              ready,
   output logic              txd
);
   import serial_mp_pkg::*;

   localparam int unsigned FRAME_W = DATA_W + 4;
   localparam int unsigned OSR_W   = $clog2(OSR);
   localparam int unsigned BCNT_W  = $clog2(FRAME_W + 1);

   logic               busy;
   logic [FRAME_W-1:0] shreg;
   logic [BCNT_W-1:0]  bits_left;
   logic [OSR_W-1:0]   os_cnt;
   logic               txd_q;
   logic               extra_on;
   logic               extra_bit;
   logic [FRAME_W-1:0] frame;
   logic [BCNT_W-1:0]  nbits;

   assign extra_on  = mp_mode | par_en;
   assign extra_bit = mp_mode ? flag : parity_bit(32'(data), DATA_W, par_odd);

   always_comb begin
      if (extra_on) frame = {2'b11, extra_bit, data, 1'b0};
      else          frame = {3'b111, data, 1'b0};
      nbits = BCNT_W'(DATA_W + 2) + BCNT_W'(extra_on) + BCNT_W'(two_stop);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         shreg     <= '1;
         bits_left <= '0;
         os_cnt    <= '0;
         txd_q     <= 1'b1;
      end else if (!busy) begin
         txd_q <= 1'b1;
         if (valid) begin
            busy      <= 1'b1;
            shreg     <= frame;
            bits_left <= nbits;
            os_cnt    <= '0;
            txd_q     <= frame[0];
         end
      end else if (tick) begin
         if (os_cnt == OSR_W'(OSR - 1)) begin
            os_cnt <= '0;
            if (bits_left == BCNT_W'(1)) begin
               busy  <= 1'b0;
               txd_q <= 1'b1;
            end else begin
               shreg     <= {1'b1, shreg[FRAME_W-1:1]};
               txd_q     <= shreg[1];
               bits_left <= bits_left - 1'b1;
            end
         end else begin
            os_cnt <= os_cnt + 1'b1;
         end
      end
   end

   assign ready = !busy;
   assign txd   = txd_q;

   // R1
   tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> txd_q);
   // R1
   tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd_q);
   // R2
   tx_bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bits_left != '0 && bits_left <= BCNT_W'(FRAME_W)));

endmodule

// File: rtl/mp_rx.sv
module mp_rx #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              mp_mode,
   input  logic              wait_id,
   output logic [DATA_W-1:0] data,
   output logic              flag,
   output logic              valid,
   output logic              frame_err,
   output logic              parity_err
);
   import serial_mp_pkg::*;

   localparam int unsigned OSR_W  = $clog2(OSR);
   localparam int unsigned MID    = OSR / 2;
   localparam int unsigned SAMP_W = DATA_W + 2;
   localparam int unsigned BCNT_W = $clog2(SAMP_W + 1);

   rx_state_e          state;
   logic               rx_s1, rx_s2;
   logic [OSR_W-1:0]   os_cnt;
   logic [BCNT_W-1:0]  bit_idx;
   logic [SAMP_W-1:0]  samp_q;
   logic               extra_on;
   logic [BCNT_W-1:0]  last_idx;
   logic               got_extra;
   logic               drop;
   logic               par_bad;

   assign extra_on  = mp_mode | par_en;
   assign last_idx  = BCNT_W'(DATA_W) + BCNT_W'(extra_on);
   assign got_extra = extra_on & samp_q[DATA_W];
   assign drop      = mp_mode & wait_id & !got_extra;
   assign par_bad   = !mp_mode & par_en &
                      (parity_bit(32'(samp_q[DATA_W-1:0]), DATA_W, par_odd) != samp_q[DATA_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_s1 <= 1'b1;
         rx_s2 <= 1'b1;
      end else begin
         rx_s1 <= rxd;
         rx_s2 <= rx_s1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RX_IDLE;
         os_cnt     <= '0;
         bit_idx    <= '0;
         samp_q     <= '0;
         data       <= '0;
         flag       <= 1'b0;
         valid      <= 1'b0;
         frame_err  <= 1'b0;
         parity_err <= 1'b0;
      end else begin
         valid      <= 1'b0;
         frame_err  <= 1'b0;
         parity_err <= 1'b0;
         if (tick) begin
            unique case (state)
               RX_IDLE: begin
                  if (!rx_s2) begin
                     state  <= RX_START;
                     os_cnt <= '0;
                  end
               end
               RX_START: begin
                  if (os_cnt == OSR_W'(MID - 1)) begin
                     os_cnt  <= '0;
                     bit_idx <= '0;
                     state   <= rx_s2 ? RX_IDLE : RX_BITS;
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
               RX_BITS: begin
                  if (os_cnt == OSR_W'(OSR - 1)) begin
                     os_cnt          <= '0;
                     samp_q[bit_idx] <= rx_s2;
                     if (bit_idx == last_idx) begin
                        state      <= RX_IDLE;
                        data       <= samp_q[DATA_W-1:0];
                        flag       <= mp_mode & samp_q[DATA_W];
                        valid      <= !drop;
                        frame_err  <= !drop & !rx_s2;
                        parity_err <= !drop & par_bad;
                     end else begin
                        bit_idx <= bit_idx + 1'b1;
                     end
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   // R7
   rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
   // R8
   rx_frame_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> valid);
   // R5
   rx_parity_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      parity_err |-> (valid && !mp_mode && par_en));
   // R11
   rx_id_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && mp_mode && wait_id) |-> flag);

endmodule

// File: rtl/async_mp_serial.sv
module async_mp_serial #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OSR    = 16,
   parameter int unsigned BRR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_two_stop,
   input  logic              cfg_parity_en,
   input  logic              cfg_parity_odd,
   input  logic              cfg_mp_mode,
   input  logic [1:0]        cfg_clk_sel,
   input  logic [BRR_W-1:0]  cfg_bit_rate,
   input  logic              cfg_wait_id,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_flag,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic              txd,
   input  logic              rxd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_flag,
   output logic              rx_valid,
   output logic              rx_frame_err,
   output logic              rx_parity_err
);
   if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
      $error("OSR must be a power of two of at least 4");
   end
   if (DATA_W < 5 || DATA_W > 16) begin : g_bad_data
      $error("DATA_W must lie between 5 and 16");
   end
   if (BRR_W < 1 || BRR_W > 16) begin : g_bad_brr
      $error("BRR_W must lie between 1 and 16");
   end

   logic tick;

   mp_baud_gen #(.BRR_W(BRR_W), .SEL_W(2), .PRE_LOG(2)) u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_sel  (cfg_clk_sel),
      .bit_rate (cfg_bit_rate),
      .tick     (tick)
   );

   mp_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .two_stop (cfg_two_stop),
      .par_en   (cfg_parity_en),
      .par_odd  (cfg_parity_odd),
      .mp_mode  (cfg_mp_mode),
      .data     (tx_data),
      .flag     (tx_flag),
      .valid    (tx_valid),
      .ready    (tx_ready),
      .txd      (txd)
   );

   mp_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .rxd        (rxd),
      .par_en     (cfg_parity_en),
      .par_odd    (cfg_parity_odd),
      .mp_mode    (cfg_mp_mode),
      .wait_id    (cfg_wait_id),
      .data       (rx_data),
      .flag       (rx_flag),
      .valid      (rx_valid),
      .frame_err  (rx_frame_err),
      .parity_err (rx_parity_err)
   );

endmodule

// File: tb/sim_async_mp_serial.sv
`timescale 1ns/1ps
module sim_async_mp_serial;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_two_stop = 0, cfg_parity_en = 0, cfg_parity_odd = 0, cfg_mp_mode = 0;
   logic [1:0] cfg_clk_sel = 0;
   logic [7:0] cfg_bit_rate = 0;
   logic       cfg_wait_id = 0;
   logic [7:0] tx_data = 0;
   logic       tx_flag = 0, tx_valid = 0;
   logic       tx_ready, txd, rxd;
   logic [7:0] rx_data;
   logic       rx_flag, rx_valid, rx_frame_err, rx_parity_err;
   logic       use_loop = 1'b1;
   logic       drv_rxd = 1'b1;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   int         rx_cnt = 0;
   logic [7:0] log_data [8];
   logic       log_flag [8];
   logic       log_fe   [8];
   logic       log_pe   [8];

   always #10 clk = ~clk;
   assign rxd = use_loop ? txd : drv_rxd;

   async_mp_serial u0 (
      .clk(clk), .rst_n(rst_n), .cfg_two_stop(cfg_two_stop), .cfg_parity_en(cfg_parity_en),
      .cfg_parity_odd(cfg_parity_odd), .cfg_mp_mode(cfg_mp_mode), .cfg_clk_sel(cfg_clk_sel),
      .cfg_bit_rate(cfg_bit_rate), .cfg_wait_id(cfg_wait_id), .tx_data(tx_data),
      .tx_flag(tx_flag), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
      .rx_data(rx_data), .rx_flag(rx_flag), .rx_valid(rx_valid),
      .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         if (rx_cnt < 8) begin
            log_data[rx_cnt] = rx_data;
            log_flag[rx_cnt] = rx_flag;
            log_fe[rx_cnt]   = rx_frame_err;
            log_pe[rx_cnt]   = rx_parity_err;
         end
         rx_cnt = rx_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // {clk_sel[2], bit_rate[8], two_stop, par_en, par_odd, mp, flag, data[8]}
   localparam logic [22:0] VEC [8] = '{
      {2'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
      {2'd0, 8'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C},
      {2'd1, 8'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h81},
      {2'd1, 8'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h7E},
      {2'd2, 8'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
      {2'd2, 8'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF},
      {2'd3, 8'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h55},
      {2'd3, 8'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hC3}
   };

   // raw receive frame, LSB first: start, data, optional extra, stop
   function automatic logic [12:0] raw_frame(input logic [7:0] d, input bit ext_on,
                                             input logic ext, input logic stop);
      logic [12:0] f;
      f = '1;
      f[0] = 1'b0;
      f[8:1] = d;
      if (ext_on) begin f[9] = ext; f[10] = stop; end
      else        f[9] = stop;
      return f;
   endfunction

   task automatic drive_frame(input logic [12:0] f, input int n);
      for (int i = 0; i < n; i++) begin
         drv_rxd = f[i];
         repeat (16) @(negedge clk);
      end
      drv_rxd = 1'b1;
   endtask

   task automatic set_cfg(input logic [1:0] sel, input logic [7:0] brr, input logic ts,
                          input logic pe, input logic po, input logic mp, input logic wid);
      @(negedge clk);
      cfg_clk_sel = sel; cfg_bit_rate = brr; cfg_two_stop = ts;
      cfg_parity_en = pe; cfg_parity_odd = po; cfg_mp_mode = mp; cfg_wait_id = wid;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(txd == 1'b1, "R12 txd", int'(txd), 1);
      chk(tx_ready == 1'b1, "R12 tx_ready", int'(tx_ready), 1);
      chk({rx_valid, rx_frame_err, rx_parity_err} == 3'b000, "R12 rx strobes",
          int'({rx_valid, rx_frame_err, rx_parity_err}), 0);

      // Table walk in loopback: R1 R2 R3 R4 R5 R7
      for (int v = 0; v < 8; v++) begin
         logic [22:0] e;
         int p, nb, dur, k;
         bit ext_on;
         logic ext;
         logic [11:0] exp_bits, seen;
         e = VEC[v];
         set_cfg(e[22:21], e[20:13], e[12], e[11], e[10], e[9], 1'b0);
         p = (int'(e[20:13]) + 1) * (1 << (2 * int'(e[22:21])));
         ext_on = e[9] | e[11];
         ext = e[9] ? e[8] : (^e[7:0] ^ e[10]);
         exp_bits = '1;
         exp_bits[0] = 1'b0;
         exp_bits[8:1] = e[7:0];
         if (ext_on) exp_bits[9] = ext;
         nb = 10 + int'(ext_on) + int'(e[12]);
         rx_cnt = 0;
         tx_data = e[7:0];
         tx_flag = e[8];
         tx_valid = 1'b1;
         @(negedge clk);
         tx_valid = 1'b0;
         dur = 0; k = 0; seen = '1;
         while (!tx_ready) begin
            if (k < nb && dur == (16 * k + 8) * p) begin
               seen[k] = txd;
               k++;
            end
            @(negedge clk);
            dur++;
         end
         // R2 R3 frame length
         chk(dur >= (16 * nb - 1) * p && dur <= 16 * nb * p + 2, "R2/R3 frame length",
             dur, 16 * nb * p);
         // R1 R4 R5 transmitted bit pattern
         chk(seen == exp_bits, "R1/R4/R5 tx bits", int'(seen), int'(exp_bits));
         repeat (4) @(negedge clk);
         chk(rx_cnt == 1, "R7 loopback count", rx_cnt, 1);
         chk(log_data[0] == e[7:0], "R7 loopback data", int'(log_data[0]), int'(e[7:0]));
         chk(log_flag[0] == (e[9] & e[8]), "R5 loopback flag", int'(log_flag[0]),
             int'(e[9] & e[8]));
         chk(!log_fe[0] && !log_pe[0], "R8/R9 no error in loopback",
             int'({log_fe[0], log_pe[0]}), 0);
      end

      // Directed tests, receive line driven by the bench, tick every clock
      use_loop = 1'b0;
      drv_rxd = 1'b1;
      set_cfg(2'd0, 8'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      repeat (40) @(negedge clk);

      // R9 even parity mismatch and match
      rx_cnt = 0;
      drive_frame(raw_frame(8'h01, 1, 1'b0, 1'b1), 11);
      repeat (40) @(negedge clk);
      chk(rx_cnt == 1 && log_pe[0] && !log_fe[0], "R9 parity mismatch",
          int'({rx_cnt[1:0], log_pe[0], log_fe[0]}), 6);
      rx_cnt = 0;
      drive_frame(raw_frame(8'h01, 1, 1'b1, 1'b1), 11);
      repeat (40) @(negedge clk);
      chk(rx_cnt == 1 && !log_pe[0], "R9 parity match", int'(log_pe[0]), 0);

      // R5 address-flag mode ignores parity setting
      set_cfg(2'd0, 8'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
      rx_cnt = 0;
      drive_frame(raw_frame(8'h01, 1, 1'b0, 1'b1), 11);
      repeat (40) @(negedge clk);
      chk(rx_cnt == 1 && !log_pe[0] && !log_flag[0] && log_data[0] == 8'h01,
          "R5 parity ignored", int'({log_pe[0], log_flag[0]}), 0);

      // R8 R9 both strobes in the same cycle
      set_cfg(2'd0, 8'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      rx_cnt = 0;
      drive_frame(raw_frame(8'h03, 1, 1'b0, 1'b0), 11);
      repeat (40) @(negedge clk);
      chk(rx_cnt >= 1 && log_fe[0] && log_pe[0] && log_data[0] == 8'h03,
          "R8/R9 frame and parity together", int'({log_fe[0], log_pe[0]}), 3);
      repeat (320) @(negedge clk);

      // R10 second stop slot low starts the next character
      set_cfg(2'd0, 8'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      repeat (40) @(negedge clk);
      rx_cnt = 0;
      drive_frame(raw_frame(8'h5A, 0, 1'b0, 1'b1), 10);
      drive_frame(raw_frame(8'h96, 0, 1'b0, 1'b1), 10);
      repeat (60) @(negedge clk);
      chk(rx_cnt == 2, "R10 back-to-back count", rx_cnt, 2);
      chk(log_data[0] == 8'h5A && log_data[1] == 8'h96, "R10 back-to-back data",
          int'({log_data[0], log_data[1]}), 16'h5A96);
      chk(!log_fe[0] && !log_fe[1], "R10 no framing error", int'({log_fe[0], log_fe[1]}), 0);

      // R6 short low pulse rejected
      rx_cnt = 0;
      drv_rxd = 1'b0;
      repeat (5) @(negedge clk);
      drv_rxd = 1'b1;
      repeat (300) @(negedge clk);
      chk(rx_cnt == 0, "R6 glitch rejected", rx_cnt, 0);

      // R11 ID filtering
      set_cfg(2'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      rx_cnt = 0;
      drive_frame(raw_frame(8'h11, 1, 1'b0, 1'b1), 11);
      repeat (40) @(negedge clk);
      chk(rx_cnt == 0, "R11 data character dropped", rx_cnt, 0);
      drive_frame(raw_frame(8'h22, 1, 1'b1, 1'b1), 11);
      repeat (40) @(negedge clk);
      chk(rx_cnt == 1 && log_flag[0] && log_data[0] == 8'h22, "R11 ID character delivered",
          int'(log_data[0]), 8'h22);
      set_cfg(2'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      rx_cnt = 0;
      drive_frame(raw_frame(8'h33, 1, 1'b0, 1'b1), 11);
      repeat (40) @(negedge clk);
      chk(rx_cnt == 1 && !log_flag[0] && log_data[0] == 8'h33, "R11 data passes without wait",
          int'(log_data[0]), 8'h33);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule